// File: doc/BRIEF.md
# Thread Context Ring Matcher

This block decides which privilege ring of a single hardware thread should accept an interrupt notification, if any ring should. A notification carries a format bit, a 4-bit target block id, a 19-bit target virtual-thread index, an ignore flag and a logical-server number. The block compares these against one context word from each of the four rings (physical, pool, OS, user), the thread's processor id and the local block id. It returns a registered result: a hit flag, a two-bit ring code and a flag for unsupported requests.

The block stores the context words in big-endian byte order, so it reverses the byte order of each word before it extracts any bit. The request CAM is the block id placed above the index and zero-extended to 24 bits. The physical ring has no stored CAM. Its CAM line is built from the local block id and an index of one set bit at position 7 above the low 7 bits of the processor id. A format-1 notification can only reach the user ring, and it needs both the OS and the user qualifiers.

Top module: `ring_ctx_matcher`

## Requirements
- R1: Each context word input is big-endian. After the byte order is reversed, the valid bit is bit 31 and the field is bits 23:0. On the raw input this puts the valid bit at raw bit 7.
- R2: The request CAM is {block id, index} (4 + 19 bits), zero-extended to 24 bits.
- R3: The physical ring (code 3) qualifies when its valid bit is set and the request CAM equals {local block id, index = 0x80 | processor id[6:0]}. Processor id bits above bit 6 have no effect.
- R4: The pool ring (code 2) qualifies when its valid bit is set and its CAM field equals the request CAM.
- R5: The OS ring (code 1) qualifies when its valid bit is set and its CAM field equals the request CAM.
- R6: In format 0 with the ignore flag clear, the reported ring is the first one that qualifies, in the order physical, pool, OS.
- R7: In format 1, only the user ring (code 0) can hit. It hits when the OS valid bit is set, the OS CAM equals the request CAM, the user valid bit is set, and the user field equals the logical-server number. The ignore flag has no effect in format 1.
- R8: In format 0 with the ignore flag set, the result is no hit with the unsupported flag set, whatever the contexts hold.
- R9: When no ring qualifies, the result is hit 0, ring 0 and unsupported 0.
- R10: A result appears one clock after a request strobe, with a result-valid pulse one cycle long. The result outputs hold their values until the next strobe.
- R11: A synchronous reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_fmt | input | 1 | Notification format (0 specific thread, 1 user level) |
| req_blk | input | 4 | Target block id |
| req_idx | input | 19 | Target virtual-thread index |
| req_ignore | input | 1 | Ignore flag for low index bits |
| req_lsrv | input | 24 | Logical-server number |
| ctx_phys | input | 32 | Physical ring context word, big-endian |
| ctx_pool | input | 32 | Pool ring context word, big-endian |
| ctx_os | input | 32 | OS ring context word, big-endian |
| ctx_user | input | 32 | User ring context word, big-endian |
| proc_id | input | 8 | Processor id of the thread |
| local_blk | input | 4 | Local block id |
| res_valid | output | 1 | Result valid pulse |
| res_hit | output | 1 | A ring accepts the notification |
| res_ring | output | 2 | Ring code: 0 user, 1 OS, 2 pool, 3 physical |
| res_unsup | output | 1 | Request kind is not supported |

## Verification
The matcher keeps no state apart from its result register, so a wrong decision shows at the ports on the pulse that follows the offending strobe and nowhere else. A wrong byte order, a wrong priority or a missed qualifier appears as a wrong hit or ring code on that pulse. A broken hold path appears as outputs that change on an idle cycle. Directed cases cover each ring alone, overlapping rings, near-miss CAMs and the unsupported mode. A run of randomized requests whose CAMs collide often is then checked against a reference model.

// File: rtl/ctxm_pkg.sv
package ctxm_pkg;

  typedef enum logic [1:0] {
    RING_USER = 2'd0,
    RING_OS   = 2'd1,
    RING_POOL = 2'd2,
    RING_PHYS = 2'd3
  } ring_e;

  // context words arrive most significant byte first
  function automatic logic [31:0] be_to_cpu(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/ctxm_word_decode.sv
module ctxm_word_decode #(
  parameter int VLD_BIT = 31,
  parameter int FLD_LSB = 0,
  parameter int FLD_W   = 24,
  parameter int OUT_W   = 24
) (
  input  logic [31:0]      raw_be,
  output logic             vld,
  output logic [OUT_W-1:0] fld
);
  logic [31:0] w_cpu;
  logic        w_unused;

  assign w_cpu    = ctxm_pkg::be_to_cpu(raw_be);
  assign vld      = w_cpu[VLD_BIT];
  assign fld      = OUT_W'(w_cpu[FLD_LSB +: FLD_W]);
  assign w_unused = ^w_cpu;
endmodule

// File: rtl/ctxm_ring_select.sv
module ctxm_ring_select
  import ctxm_pkg::*;
#(
  parameter int CAM_W   = 24,
  parameter int LS_W    = 24,
  parameter int FLD_MAX = 24
) (
  input  logic [3:0]              vld,
  input  logic [3:0][FLD_MAX-1:0] fld,
  input  logic [CAM_W-1:0]        req_cam,
  input  logic [CAM_W-1:0]        hw_cam,
  input  logic [LS_W-1:0]         req_lsrv,
  input  logic                    fmt,
  input  logic                    ignore,
  output logic                    hit,
  output ring_e                   ring,
  output logic                    unsup
);
  logic phys_ok, pool_ok, os_ok, user_ok;
  logic fld_unused;

  assign phys_ok = vld[RING_PHYS] && (hw_cam == req_cam);
  assign pool_ok = vld[RING_POOL] && (fld[RING_POOL][CAM_W-1:0] == req_cam);
  assign os_ok   = vld[RING_OS]   && (fld[RING_OS][CAM_W-1:0] == req_cam);
  assign user_ok = os_ok && vld[RING_USER] &&
                   (fld[RING_USER][LS_W-1:0] == req_lsrv);
  assign fld_unused = ^fld[RING_PHYS];

  always_comb begin
    hit   = 1'b0;
    ring  = RING_USER;
    unsup = 1'b0;
    if (!fmt) begin
      if (ignore) begin
        unsup = 1'b1;
      end else if (phys_ok) begin
        hit  = 1'b1;
        ring = RING_PHYS;
      end else if (pool_ok) begin
        hit  = 1'b1;
        ring = RING_POOL;
      end else if (os_ok) begin
        hit  = 1'b1;
        ring = RING_OS;
      end
    end else if (user_ok) begin
      hit  = 1'b1;
      ring = RING_USER;
    end
  end
endmodule

// File: rtl/ring_ctx_matcher.sv
module ring_ctx_matcher
  import ctxm_pkg::*;
#(
  parameter int BLK_W   = 4,
  parameter int IDX_W   = 19,
  parameter int CAM_W   = 24,
  parameter int LS_W    = 24,
  parameter int PID_W   = 8,
  parameter int TID_W   = 7,
  parameter int VLD_BIT = 31,
  parameter int CAM_LSB = 0,
  parameter int LS_LSB  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_fmt,
  input  logic [BLK_W-1:0] req_blk,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             req_ignore,
  input  logic [LS_W-1:0]  req_lsrv,
  input  logic [31:0]      ctx_phys,
  input  logic [31:0]      ctx_pool,
  input  logic [31:0]      ctx_os,
  input  logic [31:0]      ctx_user,
  input  logic [PID_W-1:0] proc_id,
  input  logic [BLK_W-1:0] local_blk,
  output logic             res_valid,
  output logic             res_hit,
  output logic [1:0]       res_ring,
  output logic             res_unsup
);
  localparam int FLD_MAX = (CAM_W > LS_W) ? CAM_W : LS_W;

  logic [3:0][31:0]        words;
  logic [3:0]              vld;
  logic [3:0][FLD_MAX-1:0] fld;
  logic [CAM_W-1:0]        req_cam, hw_cam;
  logic [IDX_W-1:0]        hw_idx;
  logic                    hit, unsup;
  ring_e                   ring;
  logic                    pid_unused;

  assign words = {ctx_phys, ctx_pool, ctx_os, ctx_user};

  for (genvar g = 0; g < 4; g++) begin : g_dec
    localparam bit IS_USER = (g == 0);
    ctxm_word_decode #(
      .VLD_BIT (VLD_BIT),
      .FLD_LSB (IS_USER ? LS_LSB : CAM_LSB),
      .FLD_W   (IS_USER ? LS_W : CAM_W),
      .OUT_W   (FLD_MAX)
    ) u_dec (
      .raw_be (words[g]),
      .vld    (vld[g]),
      .fld    (fld[g])
    );
  end

  assign req_cam    = CAM_W'({req_blk, req_idx});
  assign hw_idx     = IDX_W'({1'b1, proc_id[TID_W-1:0]});
  assign hw_cam     = CAM_W'({local_blk, hw_idx});
  assign pid_unused = ^proc_id;

  ctxm_ring_select #(
    .CAM_W   (CAM_W),
    .LS_W    (LS_W),
    .FLD_MAX (FLD_MAX)
  ) u_sel (
    .vld      (vld),
    .fld      (fld),
    .req_cam  (req_cam),
    .hw_cam   (hw_cam),
    .req_lsrv (req_lsrv),
    .fmt      (req_fmt),
    .ignore   (req_ignore),
    .hit      (hit),
    .ring     (ring),
    .unsup    (unsup)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_ring  <= 2'd0;
      res_unsup <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) begin
        res_hit   <= hit;
        res_ring  <= ring;
        res_unsup <= unsup;
      end
    end
  end

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(req_valid));
  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid) |-> ($stable(res_hit) && $stable(res_ring) && $stable(res_unsup)));
  assert_unsup_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_unsup) |-> (!res_hit && $past(!req_fmt && req_ignore)));
  assert_fmt1_user_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit && $past(req_fmt)) |-> (res_ring == 2'd0));
  assert_fmt0_ring_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit && !$past(req_fmt)) |-> (res_ring != 2'd0));
  assert_miss_code_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_ring == 2'd0));
endmodule

// File: tb/sim_ring_ctx_matcher.sv
module sim_ring_ctx_matcher;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_fmt = 1'b0, req_ignore = 1'b0;
  logic [3:0]  req_blk = '0, local_blk = '0;
  logic [18:0] req_idx = '0;
  logic [23:0] req_lsrv = '0;
  logic [31:0] ctx_phys = '0, ctx_pool = '0, ctx_os = '0, ctx_user = '0;
  logic [7:0]  proc_id = '0;
  logic        res_valid, res_hit, res_unsup;
  logic [1:0]  res_ring;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [3:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  ring_ctx_matcher u0 (.*);

  function automatic logic [31:0] swap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] cw(input logic v, input logic [23:0] f);
    return {v, 7'd0, f};
  endfunction

  // reference model: returns {hit, unsup, ring}
  function automatic logic [3:0] model(input logic fmt, ign, input logic [3:0] blk,
      input logic [18:0] idx, input logic [23:0] ls, input logic [31:0] p, pl, o, u,
      input logic [7:0] pid, input logic [3:0] lb);
    logic [23:0] rc, hc;
    rc = {1'b0, blk, idx};
    hc = {1'b0, lb, 11'd0, 1'b1, pid[6:0]};
    if (!fmt) begin
      if (ign) return 4'b0100;
      if (p[31] && hc == rc) return 4'b1011;
      if (pl[31] && pl[23:0] == rc) return 4'b1010;
      if (o[31] && o[23:0] == rc) return 4'b1001;
      return 4'b0000;
    end
    if (o[31] && o[23:0] == rc && u[31] && u[23:0] == ls) return 4'b1000;
    return 4'b0000;
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // driver: words given in processor byte order, sent big-endian
  task automatic send(input string tag, input logic fmt, ign, input logic [3:0] blk,
      input logic [18:0] idx, input logic [23:0] ls, input logic [31:0] p, pl, o, u,
      input logic [7:0] pid, input logic [3:0] lb);
    @(negedge clk);
    req_fmt = fmt; req_ignore = ign; req_blk = blk; req_idx = idx; req_lsrv = ls;
    ctx_phys = swap(p); ctx_pool = swap(pl); ctx_os = swap(o); ctx_user = swap(u);
    proc_id = pid; local_blk = lb; req_valid = 1'b1;
    exp_q.push_back(model(fmt, ign, blk, idx, ls, p, pl, o, u, pid, lb));
    tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R10 unexpected pulse", 4'b1111, 4'b0000);
      end else begin
        check(tag_q.pop_front(), {res_hit, res_unsup, res_ring}, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [3:0] B = 4'h5;
  localparam logic [18:0] X = 19'h1234A;
  localparam logic [23:0] RC = {1'b0, 4'h5, 19'h1234A};

  initial begin
    logic [3:0] held;
    // R11: reset with a strobe and garbage inputs
    req_valid = 1'b1; ctx_os = 32'hFFFF_FFFF; req_ignore = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {res_valid, res_hit, res_unsup, res_ring[0]}, 4'b0000);
    req_valid = 1'b0; req_ignore = 1'b0; ctx_os = '0;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R11 after reset", {res_valid, res_hit, res_ring}, 4'b0000);

    // R3: physical match, pid bit 7 ignored
    send("R3 phys", 0, 0, 4'h2, 19'h000C5, 0, cw(1, 0), 0, 0, 0, 8'hC5, 4'h2);
    idle();
    // R10: idle cycle, no pulse, outputs hold
    @(negedge clk);
    held = {res_valid, res_hit, res_unsup, res_ring[0]};
    check("R10 hold after idle", held, 4'b0101);
    check("R10 ring held", {2'b00, res_ring}, 4'b0011);
    // R3: missing thread marker bit -> miss
    send("R3 phys no marker", 0, 0, 4'h2, 19'h00045, 0, cw(1, 0), 0, 0, 0, 8'h45, 4'h2);
    // R3: wrong local block
    send("R3 phys blk miss", 0, 0, 4'h2, 19'h000C5, 0, cw(1, 0), 0, 0, 0, 8'hC5, 4'h3);
    // R4, R5
    send("R4 pool", 0, 0, B, X, 0, 0, cw(1, RC), 0, 0, 0, 0);
    send("R5 os", 0, 0, B, X, 0, 0, 0, cw(1, RC), 0, 0, 0);
    send("R5 os invalid", 0, 0, B, X, 0, 0, 0, cw(0, RC), 0, 0, 0);
    // R6: priority
    send("R6 all three", 0, 0, 4'h1, 19'h00081, 0, cw(1, 0), cw(1, 24'h080081),
         cw(1, 24'h080081), 0, 8'h01, 4'h1);
    send("R6 pool over os", 0, 0, B, X, 0, cw(1, 0), cw(1, RC), cw(1, RC), 0, 8'h00, 4'h0);
    idle();
    // R1: byte order - valid only in wrong byte must not qualify
    @(negedge clk);
    req_fmt = 0; req_ignore = 0; req_blk = B; req_idx = X; req_valid = 1'b1;
    ctx_os = {1'b1, 7'd0, RC}; ctx_phys = '0; ctx_pool = '0; ctx_user = '0;
    exp_q.push_back(4'b0000); tag_q.push_back("R1 unswapped word misses");
    send("R1 R2 swapped word hits", 0, 0, B, X, 0, 0, 0, cw(1, RC), 0, 0, 0);
    // R2: CAM bit 23 must be zero
    send("R2 top bit", 0, 0, B, X, 0, 0, 0, cw(1, RC | 24'h800000), 0, 0, 0);
    // R7
    send("R7 user", 1, 0, B, X, 24'h00ABCD, cw(1, 0), cw(1, RC), cw(1, RC), cw(1, 24'h00ABCD), 0, 0);
    send("R7 user ls miss", 1, 0, B, X, 24'h00ABCD, 0, 0, cw(1, RC), cw(1, 24'h00ABCE), 0, 0);
    send("R7 user os invalid", 1, 0, B, X, 24'h00ABCD, 0, 0, cw(0, RC), cw(1, 24'h00ABCD), 0, 0);
    send("R7 user invalid", 1, 0, B, X, 24'h00ABCD, 0, 0, cw(1, RC), cw(0, 24'h00ABCD), 0, 0);
    send("R7 ignore no effect", 1, 1, B, X, 24'h00ABCD, 0, 0, cw(1, RC), cw(1, 24'h00ABCD), 0, 0);
    send("R7 fmt1 phys no hit", 1, 0, 4'h2, 19'h000C5, 0, cw(1, 0), 0, 0, 0, 8'h45, 4'h2);
    // R8
    send("R8 unsupported", 0, 1, B, X, 0, cw(1, 0), cw(1, RC), cw(1, RC), 0, 0, 0);
    // R9
    send("R9 no match", 0, 0, B, X, 0, 0, cw(1, RC ^ 24'h1), cw(1, RC ^ 24'h2), 0, 0, 0);
    idle();
    // randomized, with frequent collisions
    for (int i = 0; i < 300; i++) begin
      logic [3:0] b, lb; logic [18:0] x; logic [23:0] rc, ls; logic [7:0] pid;
      b = 4'($urandom_range(0, 1)); lb = 4'($urandom_range(0, 1));
      pid = 8'($urandom); x = $urandom_range(0, 1) ? {11'd0, 1'b1, pid[6:0]} : 19'($urandom_range(0, 3));
      rc = {1'b0, b, x}; ls = 24'($urandom_range(0, 2));
      send("R6 R7 random", 1'($urandom), 1'($urandom_range(0, 3) == 0), b, x, ls,
           cw(1'($urandom), 0),
           cw(1'($urandom), $urandom_range(0, 1) ? rc : 24'd0),
           cw(1'($urandom), $urandom_range(0, 2) != 0 ? rc : 24'd1),
           cw(1'($urandom), 24'($urandom_range(0, 2))), pid, lb);
      if ($urandom_range(0, 2) == 0) idle();
    end
    idle();
    repeat (3) @(negedge clk);
    check("R10 all results seen", 4'(exp_q.size()), 4'd0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule